// File: doc/BRIEF.md
# Instruction Length and Skip Sequencer

This block is the front end of a small 16-bit word-addressed processor. It fetches one instruction word, splits it into a 4-bit opcode and two 6-bit operand codes, and works out from the operand codes how many extension words follow (0, 1 or 2). It reads those extension words while advancing the program counter. It then hands basic instructions to the neighbouring execute logic, or carries out the non-basic subroutine call itself.

When the execute logic reports that a conditional test failed, the sequencer does not run the next instruction. It reads that instruction's first word, decodes its length by the same rule, and moves the program counter past all of its words. The sequencer also owns the stack pointer, which the subroutine call uses. It keeps a running cycle count made up of extension-word costs, the execute cost reported by the neighbour, the extra cost of a failed test and the extra cost of a call.

The memory read port is combinational: `rd_data` must hold the word at `rd_addr` in the same cycle. Operand values come from neighbouring blocks through `jsr_target`, `cond_fail` and `op_cost`.

Top module: `insn_step_seq`

## Requirements
- R1: After reset, `pc`, `sp`, `cycles` and `skip_flag` are zero, and `dsp_valid`, `wr_en` and `illegal_evt` are low.
- R2: A fetched word is split as opcode = bits 3:0, operand a = bits 9:4 and operand b = bits 15:10. These fields appear on `dsp_opcode`, `dsp_a` and `dsp_b` while `dsp_valid` is high.
- R3: An operand code needs an extension word when it is 0x10–0x17, 0x1E or 0x1F. The instruction length is 1, plus 1 if b needs a word, plus 1 if the opcode is nonzero and a needs a word. The word for a is read before the word for b, and each is presented on `dsp_a_word` or `dsp_b_word`. After the instruction, `pc` has moved forward by the length.
- R4: `cycles` grows by 1 for each extension word read and by `op_cost` for each dispatched basic instruction. It grows by 1 more when a conditional fails, and by 2 for a call. A reserved non-basic instruction adds nothing beyond its extension words.
- R5: `cond_fail` is sampled during the `dsp_valid` cycle of opcodes 0xC–0xF. When it is high, `skip_flag` rises and the next instruction is not dispatched. `pc` then advances by that instruction's decoded length, and `skip_flag` clears the cycle after.
- R6: `cond_fail` has no effect for opcodes 0x1–0xB: `skip_flag` stays low and the following instruction is dispatched.
- R7: An instruction with opcode 0 and a = 0x01 is a call. It writes the address of the following instruction to `sp`−1 (modulo 2^16) and decrements `sp`. It then loads `pc` from `jsr_target` and raises no `dsp_valid`.
- R8: An instruction with opcode 0 and any a other than 0x01 pulses `illegal_evt` for one cycle. It writes nothing, leaves `sp` unchanged and otherwise only advances `pc` by its length.
- R9: For opcode 0 the a field never adds to the length, even when it holds a code that needs a word.
- R10: A skipped instruction with opcode 0 is measured by its b field alone. It causes no memory write, no `illegal_evt` and no `sp` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | output | 16 | Word address being read (always the program counter) |
| rd_data | input | 16 | Word at `rd_addr`, valid in the same cycle |
| wr_en | output | 1 | Stack write strobe for a call |
| wr_addr | output | 16 | Stack write address |
| wr_data | output | 16 | Return address written on a call |
| dsp_valid | output | 1 | Basic instruction handed to the execute logic this cycle |
| dsp_opcode | output | 4 | Opcode field |
| dsp_a | output | 6 | Operand a code |
| dsp_b | output | 6 | Operand b code |
| dsp_a_word | output | 16 | Extension word of operand a |
| dsp_b_word | output | 16 | Extension word of operand b |
| cond_fail | input | 1 | Execute logic reports a failed test (meaningful for opcodes 0xC–0xF) |
| op_cost | input | 4 | Execute cost of the dispatched instruction |
| jsr_target | input | 16 | Resolved call operand value |
| illegal_evt | output | 1 | One-cycle pulse for a reserved non-basic instruction |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| skip_flag | output | 1 | A skip is pending |
| cycles | output | 32 | Accumulated cycle count |

## Verification
The assertions assume that `cond_fail`, `op_cost` and `jsr_target` are stable through the cycle in which they are sampled. They also assume that `rd_data` always reflects the current `rd_addr` with no wait state. The bench models memory as a combinational array. It sets the three neighbour inputs once per scenario, before reset is released, and never changes them while a program runs. The cycle count never approaches the counter width, so the monotonic-count check always holds.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [2:0] {
      ST_FETCH = 3'd0,
      ST_EXTA  = 3'd1,
      ST_EXTB  = 3'd2,
      ST_EXEC  = 3'd3,
      ST_SKIP  = 3'd4
   } seq_state_e;
endpackage

// File: rtl/seq_word_decode.sv
module seq_word_decode #(
   parameter int WORD_W   = 16,
   parameter int OPC_W    = 4,
   parameter int OPD_W    = 6,
   parameter int IDX_BASE = 16,
   parameter int IDX_CNT  = 8,
   parameter int MEM_CODE = 30,
   parameter int LIT_CODE = 31
) (
   input  logic [WORD_W-1:0] word,
   output logic [OPC_W-1:0]  opc,
   output logic [OPD_W-1:0]  fa,
   output logic [OPD_W-1:0]  fb,
   output logic              is_ext,
   output logic              need_a,
   output logic              need_b,
   output logic [1:0]        len
);
   localparam int A_LO = OPC_W;
   localparam int B_LO = OPC_W + OPD_W;

   generate
      if (WORD_W != OPC_W + 2 * OPD_W) begin : g_bad_split
         $error("word width must equal opcode width plus two operand widths");
      end
      if (LIT_CODE >= (1 << OPD_W) || MEM_CODE >= (1 << OPD_W)) begin : g_bad_code
         $error("extension codes do not fit in the operand field");
      end
      if (IDX_BASE + IDX_CNT > (1 << OPD_W)) begin : g_bad_range
         $error("indexed code range does not fit in the operand field");
      end
   endgenerate

   function automatic logic takes_word(input logic [OPD_W-1:0] c);
      int v;
      v = int'(c);
      return ((v >= IDX_BASE) && (v < IDX_BASE + IDX_CNT)) ||
             (v == MEM_CODE) || (v == LIT_CODE);
   endfunction

   assign opc    = word[A_LO-1:0];
   assign fa     = word[B_LO-1:A_LO];
   assign fb     = word[WORD_W-1:B_LO];
   assign is_ext = (opc == '0);
   assign need_a = !is_ext && takes_word(fa);
   assign need_b = takes_word(fb);
   assign len    = 2'd1 + {1'b0, need_a} + {1'b0, need_b};
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl import seq_pkg::*; #(
   parameter int WORD_W    = 16,
   parameter int OPC_W     = 4,
   parameter int OPD_W     = 6,
   parameter int COST_W    = 4,
   parameter int COND_BASE = 12,
   parameter int CALL_CODE = 1,
   parameter int CALL_COST = 2,
   parameter int FAIL_COST = 1,
   parameter int INC_W     = COST_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [WORD_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic              wr_en,
   output logic [WORD_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              dsp_valid,
   output logic [OPC_W-1:0]  dsp_opcode,
   output logic [OPD_W-1:0]  dsp_a,
   output logic [OPD_W-1:0]  dsp_b,
   output logic [WORD_W-1:0] dsp_a_word,
   output logic [WORD_W-1:0] dsp_b_word,
   input  logic              cond_fail,
   input  logic [COST_W-1:0] op_cost,
   input  logic [WORD_W-1:0] jsr_target,
   output logic              illegal_evt,
   output logic [WORD_W-1:0] pc,
   output logic [WORD_W-1:0] sp,
   output logic              skip_flag,
   output logic [INC_W-1:0]  cyc_inc
);
   generate
      if (CALL_COST >= (1 << INC_W) || FAIL_COST >= (1 << INC_W)) begin : g_bad_cost
         $error("fixed costs do not fit the increment width");
      end
      if (COND_BASE >= (1 << OPC_W) || COND_BASE < 1) begin : g_bad_cond
         $error("conditional opcode base out of range");
      end
   endgenerate

   seq_state_e        state;
   logic [OPC_W-1:0]  opc_q;
   logic [OPD_W-1:0]  fa_q;
   logic [OPD_W-1:0]  fb_q;
   logic              ext_q;
   logic              needb_q;
   logic [WORD_W-1:0] wa_q;
   logic [WORD_W-1:0] wb_q;
   logic [WORD_W-1:0] pc_q;
   logic [WORD_W-1:0] sp_q;
   logic              skip_q;

   logic [OPC_W-1:0]  p_opc;
   logic [OPD_W-1:0]  p_fa;
   logic [OPD_W-1:0]  p_fb;
   logic              p_ext;
   logic              p_need_a;
   logic              p_need_b;
   logic [1:0]        p_len;

   // one decoder serves both the normal fetch and the skip measurement
   seq_word_decode #(
      .WORD_W (WORD_W),
      .OPC_W  (OPC_W),
      .OPD_W  (OPD_W)
   ) u_peek (
      .word   (rd_data),
      .opc    (p_opc),
      .fa     (p_fa),
      .fb     (p_fb),
      .is_ext (p_ext),
      .need_a (p_need_a),
      .need_b (p_need_b),
      .len    (p_len)
   );

   logic in_exec, exec_basic, exec_call, exec_resv, is_cond, fail_hit;

   always_comb begin
      in_exec    = (state == ST_EXEC);
      exec_basic = in_exec && !ext_q;
      exec_call  = in_exec && ext_q && (fa_q == OPD_W'(CALL_CODE));
      exec_resv  = in_exec && ext_q && (fa_q != OPD_W'(CALL_CODE));
      is_cond    = (opc_q >= OPC_W'(COND_BASE));
      fail_hit   = exec_basic && is_cond && cond_fail;
   end

   assign rd_addr     = pc_q;
   assign wr_en       = exec_call;
   assign wr_addr     = sp_q - WORD_W'(1);
   assign wr_data     = pc_q;
   assign dsp_valid   = exec_basic;
   assign dsp_opcode  = opc_q;
   assign dsp_a       = fa_q;
   assign dsp_b       = fb_q;
   assign dsp_a_word  = wa_q;
   assign dsp_b_word  = wb_q;
   assign illegal_evt = exec_resv;
   assign pc          = pc_q;
   assign sp          = sp_q;
   assign skip_flag   = skip_q;

   always_comb begin
      cyc_inc = '0;
      case (state)
         ST_EXTA, ST_EXTB: cyc_inc = INC_W'(1);
         ST_EXEC: begin
            if (!ext_q)
               cyc_inc = INC_W'(op_cost) + (fail_hit ? INC_W'(FAIL_COST) : INC_W'(0));
            else if (fa_q == OPD_W'(CALL_CODE))
               cyc_inc = INC_W'(CALL_COST);
         end
         default: cyc_inc = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_FETCH;
         opc_q   <= '0;
         fa_q    <= '0;
         fb_q    <= '0;
         ext_q   <= 1'b0;
         needb_q <= 1'b0;
         wa_q    <= '0;
         wb_q    <= '0;
         pc_q    <= '0;
         sp_q    <= '0;
         skip_q  <= 1'b0;
      end else begin
         case (state)
            ST_FETCH: begin
               opc_q   <= p_opc;
               fa_q    <= p_fa;
               fb_q    <= p_fb;
               ext_q   <= p_ext;
               needb_q <= p_need_b;
               pc_q    <= pc_q + WORD_W'(1);
               if (p_need_a)      state <= ST_EXTA;
               else if (p_need_b) state <= ST_EXTB;
               else               state <= ST_EXEC;
            end
            ST_EXTA: begin
               wa_q  <= rd_data;
               pc_q  <= pc_q + WORD_W'(1);
               state <= needb_q ? ST_EXTB : ST_EXEC;
            end
            ST_EXTB: begin
               wb_q  <= rd_data;
               pc_q  <= pc_q + WORD_W'(1);
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               if (exec_call) begin
                  sp_q <= sp_q - WORD_W'(1);
                  pc_q <= jsr_target;
               end
               if (fail_hit) begin
                  skip_q <= 1'b1;
                  state  <= ST_SKIP;
               end else begin
                  state  <= ST_FETCH;
               end
            end
            ST_SKIP: begin
               pc_q   <= pc_q + WORD_W'(p_len);
               skip_q <= 1'b0;
               state  <= ST_FETCH;
            end
            default: state <= ST_FETCH;
         endcase
      end
   end

   // R5
   skip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_valid && cond_fail && (dsp_opcode >= OPC_W'(COND_BASE))) |=> skip_flag);

   // R6
   no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_valid && (dsp_opcode < OPC_W'(COND_BASE))) |=> !skip_flag);

   // R5
   skip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_flag |=> !skip_flag);

   // R7
   call_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (sp == $past(wr_addr)));

   // R7
   call_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (pc == $past(jsr_target)));

   // R8
   excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dsp_valid, wr_en, illegal_evt}));

   // R8
   resv_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_evt |=> $stable(sp));
endmodule

// File: rtl/seq_cost.sv
module seq_cost #(
   parameter int CYC_W    = 32,
   parameter int INC_W    = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] cyc_inc,
   output logic [CYC_W-1:0] cycles
);
   generate
      if (INC_W > CYC_W) begin : g_bad_width
         $error("cycle counter narrower than its increment");
      end
   endgenerate

   logic [CYC_W:0]   sum;
   logic [CYC_W-1:0] next;

   assign sum = {1'b0, cycles} + (CYC_W + 1)'(cyc_inc);

   generate
      if (SATURATE) begin : g_sat
         assign next = sum[CYC_W] ? {CYC_W{1'b1}} : sum[CYC_W-1:0];

         // R4
         cyc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cycles >= $past(cycles));
      end else begin : g_wrap
         assign next = sum[CYC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cycles <= '0;
      else        cycles <= next;
   end
endmodule

// File: rtl/insn_step_seq.sv
module insn_step_seq #(
   parameter int WORD_W    = 16,
   parameter int OPC_W     = 4,
   parameter int OPD_W     = 6,
   parameter int COST_W    = 4,
   parameter int CYC_W     = 32,
   parameter int COND_BASE = 12,
   parameter int CALL_CODE = 1,
   parameter int CALL_COST = 2,
   parameter int FAIL_COST = 1,
   parameter bit SATURATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [WORD_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic              wr_en,
   output logic [WORD_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              dsp_valid,
   output logic [OPC_W-1:0]  dsp_opcode,
   output logic [OPD_W-1:0]  dsp_a,
   output logic [OPD_W-1:0]  dsp_b,
   output logic [WORD_W-1:0] dsp_a_word,
   output logic [WORD_W-1:0] dsp_b_word,
   input  logic              cond_fail,
   input  logic [COST_W-1:0] op_cost,
   input  logic [WORD_W-1:0] jsr_target,
   output logic              illegal_evt,
   output logic [WORD_W-1:0] pc,
   output logic [WORD_W-1:0] sp,
   output logic              skip_flag,
   output logic [CYC_W-1:0]  cycles
);
   localparam int INC_W = COST_W + 2;

   logic [INC_W-1:0] cyc_inc;

   seq_ctrl #(
      .WORD_W    (WORD_W),
      .OPC_W     (OPC_W),
      .OPD_W     (OPD_W),
      .COST_W    (COST_W),
      .COND_BASE (COND_BASE),
      .CALL_CODE (CALL_CODE),
      .CALL_COST (CALL_COST),
      .FAIL_COST (FAIL_COST),
      .INC_W     (INC_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .dsp_valid   (dsp_valid),
      .dsp_opcode  (dsp_opcode),
      .dsp_a       (dsp_a),
      .dsp_b       (dsp_b),
      .dsp_a_word  (dsp_a_word),
      .dsp_b_word  (dsp_b_word),
      .cond_fail   (cond_fail),
      .op_cost     (op_cost),
      .jsr_target  (jsr_target),
      .illegal_evt (illegal_evt),
      .pc          (pc),
      .sp          (sp),
      .skip_flag   (skip_flag),
      .cyc_inc     (cyc_inc)
   );

   seq_cost #(
      .CYC_W    (CYC_W),
      .INC_W    (INC_W),
      .SATURATE (SATURATE)
   ) u_cost (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_inc (cyc_inc),
      .cycles  (cycles)
   );

   // R1
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!dsp_valid && !wr_en && !illegal_evt));
endmodule

// File: tb/sim_insn_step_seq.sv
module sim_insn_step_seq;
   logic        clk;
   logic        rst_n;
   logic [15:0] rd_addr, rd_data, wr_addr, wr_data;
   logic        wr_en, dsp_valid, cond_fail, illegal_evt, skip_flag;
   logic [3:0]  dsp_opcode, op_cost;
   logic [5:0]  dsp_a, dsp_b;
   logic [15:0] dsp_a_word, dsp_b_word, jsr_target, pc, sp;
   logic [31:0] cycles;

   logic [15:0] mem [0:255];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int dsp_cnt, wr_cnt, ill_cnt, skip_seen;
   logic [3:0]  last_opc;
   logic [5:0]  last_a, last_b;
   logic [15:0] last_aw, last_bw;

   insn_step_seq u0 (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dsp_valid(dsp_valid), .dsp_opcode(dsp_opcode), .dsp_a(dsp_a), .dsp_b(dsp_b),
      .dsp_a_word(dsp_a_word), .dsp_b_word(dsp_b_word), .cond_fail(cond_fail),
      .op_cost(op_cost), .jsr_target(jsr_target), .illegal_evt(illegal_evt),
      .pc(pc), .sp(sp), .skip_flag(skip_flag), .cycles(cycles)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   assign rd_data = mem[rd_addr[7:0]];

   always @(posedge clk) if (wr_en) mem[wr_addr[7:0]] <= wr_data;

   always @(negedge clk) begin
      if (rst_n) begin
         if (dsp_valid) begin
            dsp_cnt++;
            last_opc = dsp_opcode; last_a = dsp_a; last_b = dsp_b;
            last_aw = dsp_a_word;  last_bw = dsp_b_word;
         end
         if (wr_en)       wr_cnt++;
         if (illegal_evt) ill_cnt++;
         if (skip_flag)   skip_seen++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
   endtask

   task automatic restart(input logic cf, input logic [3:0] cost, input logic [15:0] tgt);
      cond_fail = cf; op_cost = cost; jsr_target = tgt;
      rst_n = 1'b0;
      @(posedge clk); @(posedge clk); #5;
      dsp_cnt = 0; wr_cnt = 0; ill_cnt = 0; skip_seen = 0;
      rst_n = 1'b1;
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic t_reset();
      clear_mem();
      restart(1'b0, 4'd1, 16'h0000);
      chk("R1 pc", pc, 0);
      chk("R1 sp", sp, 0);
      chk("R1 cycles", cycles, 0);
      chk("R1 skip", skip_flag, 0);
      chk("R1 quiet", {dsp_valid, wr_en, illegal_evt}, 0);
   endtask

   task automatic t_single();
      clear_mem();
      mem[0] = 16'h8401;
      restart(1'b0, 4'd1, 16'h0000);
      run(2);
      chk("R3 pc one word", pc, 1);
      chk("R2 dsp count", dsp_cnt, 1);
      chk("R2 fields", {last_opc, last_a, last_b}, {4'h1, 6'h00, 6'h21});
      chk("R4 cycles single", cycles, 1);
   endtask

   task automatic t_three();
      clear_mem();
      mem[0] = 16'h41E2; mem[1] = 16'h1234; mem[2] = 16'h5678;
      restart(1'b0, 4'd2, 16'h0000);
      run(4);
      chk("R3 pc three words", pc, 3);
      chk("R2 fields three", {last_opc, last_a, last_b}, {4'h2, 6'h1E, 6'h10});
      chk("R3 a word", last_aw, 16'h1234);
      chk("R3 b word", last_bw, 16'h5678);
      chk("R4 cycles ext", cycles, 4);
   endtask

   task automatic t_b_only();
      clear_mem();
      mem[0] = 16'h7C53; mem[1] = 16'h00AA;
      restart(1'b0, 4'd2, 16'h0000);
      run(3);
      chk("R3 pc b only", pc, 2);
      chk("R3 b word only", last_bw, 16'h00AA);
      chk("R4 cycles b only", cycles, 3);
   endtask

   task automatic t_reserved();
      clear_mem();
      mem[0] = 16'h81F0; mem[1] = 16'h7800; mem[2] = 16'h0033;
      restart(1'b0, 4'd3, 16'h0000);
      run(2);
      chk("R9 pc ignores a", pc, 1);
      chk("R8 illegal first", ill_cnt, 1);
      run(3);
      chk("R8 pc after b word", pc, 3);
      chk("R8 illegal count", ill_cnt, 2);
      chk("R8 no write", wr_cnt, 0);
      chk("R8 no dispatch", dsp_cnt, 0);
      chk("R8 sp kept", sp, 0);
      chk("R4 reserved cost", cycles, 1);
   endtask

   task automatic t_call();
      clear_mem();
      mem[0] = 16'h7C10; mem[1] = 16'h0040; mem[8'h40] = 16'h8401;
      restart(1'b0, 4'd1, 16'h0040);
      run(3);
      chk("R7 pc target", pc, 16'h0040);
      chk("R7 sp dec", sp, 16'hFFFF);
      chk("R7 return addr", mem[8'hFF], 16'h0002);
      chk("R7 no dispatch", dsp_cnt, 0);
      chk("R4 call cost", cycles, 3);
      run(2);
      chk("R7 runs target", dsp_cnt, 1);
      chk("R7 pc after target", pc, 16'h0041);
      chk("R4 cycles after call", cycles, 4);
   endtask

   task automatic t_skip_fail();
      clear_mem();
      mem[0] = 16'h840C; mem[1] = 16'h41E2; mem[2] = 16'h1111; mem[3] = 16'h2222;
      mem[4] = 16'h8401;
      restart(1'b1, 4'd2, 16'h0000);
      run(2);
      chk("R5 skip raised", skip_flag, 1);
      run(1);
      chk("R5 skip cleared", skip_flag, 0);
      chk("R5 pc past skipped", pc, 4);
      run(2);
      chk("R5 skipped not dispatched", dsp_cnt, 2);
      chk("R6 set after skip", last_opc, 4'h1);
      chk("R5 pc end", pc, 5);
      chk("R4 fail cost", cycles, 5);
   endtask

   task automatic t_skip_pass();
      clear_mem();
      mem[0] = 16'h840C; mem[1] = 16'h41E2; mem[2] = 16'h1111; mem[3] = 16'h2222;
      restart(1'b0, 4'd2, 16'h0000);
      run(6);
      chk("R5 pass no skip", skip_seen, 0);
      chk("R5 pass executes", dsp_cnt, 2);
      chk("R5 pass opcode", last_opc, 4'h2);
      chk("R5 pass pc", pc, 4);
      chk("R4 pass cycles", cycles, 6);
   endtask

   task automatic t_non_cond();
      clear_mem();
      mem[0] = 16'h8402; mem[1] = 16'h8401;
      restart(1'b1, 4'd1, 16'h0000);
      run(4);
      chk("R6 no skip", skip_seen, 0);
      chk("R6 both dispatched", dsp_cnt, 2);
      chk("R6 pc", pc, 2);
      chk("R6 cycles", cycles, 2);
   endtask

   task automatic t_skip_ext();
      clear_mem();
      mem[0] = 16'h840C; mem[1] = 16'h85F0; mem[2] = 16'h8401;
      restart(1'b1, 4'd1, 16'h0000);
      run(5);
      chk("R10 pc over reserved", pc, 3);
      chk("R10 no illegal", ill_cnt, 0);
      chk("R10 dispatch count", dsp_cnt, 2);
      clear_mem();
      mem[0] = 16'h840F; mem[1] = 16'h7C10; mem[2] = 16'h0040; mem[3] = 16'h8401;
      restart(1'b1, 4'd1, 16'h0040);
      run(5);
      chk("R10 pc over call", pc, 4);
      chk("R10 no write", wr_cnt, 0);
      chk("R10 sp kept", sp, 0);
      chk("R10 cycles", cycles, 3);
   endtask

   initial begin
      rst_n = 1'b0; cond_fail = 1'b0; op_cost = '0; jsr_target = '0;
      t_reset();
      t_single();
      t_three();
      t_b_only();
      t_reserved();
      t_call();
      t_skip_fail();
      t_skip_pass();
      t_non_cond();
      t_skip_ext();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule